// File: doc/BRIEF.md
# Low-Side Output Fault Supervisor

This block is the digital guard placed next to a low-side power switch. A host or sequencer drives a single on/off command; four comparator flags arrive from the analog side, already synchronous to the block clock: over-current (load shorted to the supply), over-temperature, open load and load shorted to ground. The block produces the gate enable for the output stage, a sticky four-bit fault status and a latched-off indication.

An over-current flag has to persist for a programmable number of consecutive cycles while the output conducts before the output is shut off, so short glitches pass without effect. An over-temperature event switches the output off at once and then restarts it automatically once the die has cooled, for a bounded number of attempts; when that budget is exhausted, the output latches off. A clean stretch of conduction refills the budget. Open-load and short-to-ground flags only report status. They are trusted only while the output is commanded off and only after two agreeing samples. A single clear pulse from the host wipes the status and releases the latch.

Top module: `lsd_fault_supervisor`

## Requirements
- R1: With no fault active, `gate_en` equals `drive_cmd` in the same cycle; during reset `gate_en` is 0, `fault_status` is 0 and `latched_off` is 0.
- R2: When `oc_flag` is high while `gate_en` is high for OC_DEB consecutive cycles, `gate_en` goes low and `latched_off` and `fault_status[0]` go high from the next cycle. A run of fewer consecutive cycles, broken by a low cycle, leaves the output running.
- R3: `oc_flag` has no effect while `gate_en` is low.
- R4: `ot_flag` high in a cycle with `gate_en` high makes `gate_en` low and sets `fault_status[1]` from the next cycle.
- R5: After a thermal trip the output stays blocked until `ot_flag` has been low for COOL_CNT consecutive cycles. It is enabled again (if commanded) from the cycle after the last of them, and any high cycle restarts the count.
- R6: The first MAX_RETRY thermal trips restart automatically. The next trip, with no good run in between, sets `latched_off`.
- R7: GOOD_RUN consecutive cycles with `gate_en` high and both `oc_flag` and `ot_flag` low restore the full restart budget.
- R8: `ol_flag` and `sg_flag` are sampled only while `drive_cmd` is low. Two consecutive high samples set `fault_status[2]` (open load) or `fault_status[3]` (short to ground), respectively. These flags never change `gate_en`.
- R9: While `latched_off` is high, `gate_en` stays low regardless of `drive_cmd`.
- R10: A `host_clear` cycle zeroes `fault_status`, `latched_off` and the restart count from the next cycle. It takes priority over any fault that sets a bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_cmd | input | 1 | Requested output state, 1 = on |
| oc_flag | input | 1 | Over-current comparator |
| ot_flag | input | 1 | Over-temperature comparator |
| ol_flag | input | 1 | Open-load comparator |
| sg_flag | input | 1 | Short-to-ground comparator |
| host_clear | input | 1 | One-cycle clear of status and latch |
| gate_en | output | 1 | Gate enable for the power stage |
| fault_status | output | 4 | Sticky faults: [0] over-current, [1] over-temp, [2] open load, [3] short to ground |
| latched_off | output | 1 | Output held off until cleared |

## Verification
`gate_en` follows the command combinationally, so the bench reads it 1 ns after driving `drive_cmd`. Every registered result (a status bit, the latch, the end of a cool-down) is due on the clock edge that closes the qualifying cycle. The bench therefore drives inputs just after a falling edge and reads results on a later falling edge. It counts exactly OC_DEB, COOL_CNT or GOOD_RUN edges, and also checks one edge earlier, where the result must still be absent.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  localparam int unsigned FLT_OC  = 0;
  localparam int unsigned FLT_OT  = 1;
  localparam int unsigned FLT_OL  = 2;
  localparam int unsigned FLT_SG  = 3;
  localparam int unsigned FLT_NUM = 4;

  typedef enum logic {TH_RUN = 1'b0, TH_COOL = 1'b1} th_state_e;

  // bits needed to count 0 .. n-1 (at least one)
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // bits needed to hold 0 .. n
  function automatic int unsigned val_w(input int unsigned n);
    return cnt_w(n + 1);
  endfunction
endpackage

// File: rtl/lsd_oc_qual.sv
module lsd_oc_qual #(
  parameter int unsigned OC_DEB = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic gate_on,
  input  logic oc_flag,
  output logic oc_trip
);
  localparam int unsigned W = lsd_pkg::cnt_w(OC_DEB);
  localparam logic [W-1:0] LAST = W'(OC_DEB - 1);

  logic [W-1:0] run_q;
  logic         oc_live;

  assign oc_live = gate_on & oc_flag;
  assign oc_trip = oc_live & (run_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (clr || !oc_live)   run_q <= '0;
    else if (oc_trip)           run_q <= '0;
    else                        run_q <= run_q + 1'b1;
  end

  if (OC_DEB > 1) begin : g_deb_chk
    p_trip_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      oc_trip |-> ($past(oc_flag) && $past(gate_on)));
  end
endmodule

// File: rtl/lsd_thermal_retry.sv
module lsd_thermal_retry #(
  parameter int unsigned MAX_RETRY = 3,
  parameter int unsigned COOL_CNT  = 8,
  parameter int unsigned GOOD_RUN  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic gate_on,
  input  logic ot_flag,
  input  logic oc_flag,
  output logic th_block,
  output logic ot_trip,
  output logic latch_req
);
  import lsd_pkg::*;
  localparam int unsigned CW = cnt_w(COOL_CNT);
  localparam int unsigned GW = cnt_w(GOOD_RUN);
  localparam int unsigned RW = val_w(MAX_RETRY);
  localparam logic [CW-1:0] COOL_LAST = CW'(COOL_CNT - 1);
  localparam logic [GW-1:0] GOOD_LAST = GW'(GOOD_RUN - 1);
  localparam logic [RW-1:0] RETRY_MAX = RW'(MAX_RETRY);

  th_state_e     state_q;
  logic [CW-1:0] cool_q;
  logic [GW-1:0] good_q;
  logic [RW-1:0] retry_q;
  logic          good_ok, good_done, cool_done;

  assign ot_trip   = gate_on & ot_flag;
  assign latch_req = ot_trip & (retry_q == RETRY_MAX);
  assign th_block  = (state_q == TH_COOL);
  assign good_ok   = gate_on & ~ot_flag & ~oc_flag;
  assign good_done = good_ok & (good_q == GOOD_LAST);
  assign cool_done = th_block & ~ot_flag & (cool_q == COOL_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TH_RUN; cool_q <= '0; good_q <= '0; retry_q <= '0;
    end else if (clr) begin
      state_q <= TH_RUN; cool_q <= '0; good_q <= '0; retry_q <= '0;
    end else if (state_q == TH_RUN) begin
      cool_q <= '0;
      if (ot_trip) begin
        good_q <= '0;
        if (!latch_req) begin
          state_q <= TH_COOL;
          retry_q <= retry_q + 1'b1;
        end
      end else if (good_done) begin
        good_q  <= '0;
        retry_q <= '0;
      end else if (good_ok) begin
        good_q  <= good_q + 1'b1;
      end else begin
        good_q  <= '0;
      end
    end else begin
      good_q <= '0;
      if (ot_flag)        cool_q <= '0;
      else if (cool_done) begin
        cool_q  <= '0;
        state_q <= TH_RUN;
      end else            cool_q <= cool_q + 1'b1;
    end
  end

  p_restart_after_cool_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(th_block) |-> !$past(ot_flag));
  p_retry_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q <= RETRY_MAX);
  p_good_refills_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (good_done && !clr) |=> (retry_q == '0));
endmodule

// File: rtl/lsd_diag_filter.sv
module lsd_diag_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic drive_cmd,
  input  logic flag,
  output logic hit
);
  logic seen_q;
  logic sample;

  assign sample = ~drive_cmd & flag;
  assign hit    = sample & seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   seen_q <= 1'b0;
    else if (clr) seen_q <= 1'b0;
    else          seen_q <= sample;
  end

  p_two_samples_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($past(flag) && !$past(drive_cmd)));
endmodule

// File: rtl/lsd_fault_supervisor.sv
module lsd_fault_supervisor #(
  parameter int unsigned OC_DEB    = 4,
  parameter int unsigned COOL_CNT  = 8,
  parameter int unsigned GOOD_RUN  = 16,
  parameter int unsigned MAX_RETRY = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       drive_cmd,
  input  logic       oc_flag,
  input  logic       ot_flag,
  input  logic       ol_flag,
  input  logic       sg_flag,
  input  logic       host_clear,
  output logic       gate_en,
  output logic [3:0] fault_status,
  output logic       latched_off
);
  import lsd_pkg::*;

  logic               latch_q;
  logic [FLT_NUM-1:0] status_q;
  logic [FLT_NUM-1:0] set_v;
  logic               th_block, ot_trip, th_latch_req, oc_trip;
  logic [1:0]         diag_flag, diag_hit;

  assign gate_en = rst_n & drive_cmd & ~latch_q & ~th_block;

  lsd_oc_qual #(.OC_DEB(OC_DEB)) i_oc (
    .clk(clk), .rst_n(rst_n), .clr(host_clear),
    .gate_on(gate_en), .oc_flag(oc_flag), .oc_trip(oc_trip));

  lsd_thermal_retry #(.MAX_RETRY(MAX_RETRY), .COOL_CNT(COOL_CNT), .GOOD_RUN(GOOD_RUN)) i_th (
    .clk(clk), .rst_n(rst_n), .clr(host_clear), .gate_on(gate_en),
    .ot_flag(ot_flag), .oc_flag(oc_flag), .th_block(th_block),
    .ot_trip(ot_trip), .latch_req(th_latch_req));

  assign diag_flag = {sg_flag, ol_flag};
  for (genvar d = 0; d < 2; d++) begin : g_diag
    lsd_diag_filter i_diag (
      .clk(clk), .rst_n(rst_n), .clr(host_clear), .drive_cmd(drive_cmd),
      .flag(diag_flag[d]), .hit(diag_hit[d]));
  end

  always_comb begin
    set_v         = '0;
    set_v[FLT_OC] = oc_trip;
    set_v[FLT_OT] = ot_trip;
    set_v[FLT_OL] = diag_hit[0];
    set_v[FLT_SG] = diag_hit[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      latch_q  <= 1'b0;
    end else if (host_clear) begin
      status_q <= '0;
      latch_q  <= 1'b0;
    end else begin
      status_q <= status_q | set_v;
      latch_q  <= latch_q | oc_trip | th_latch_req;
    end
  end

  assign fault_status = status_q;
  assign latched_off  = latch_q;

  p_oc_latches_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_trip && !host_clear) |=> (latched_off && fault_status[FLT_OC]));
  p_ot_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_trip && !host_clear) |=> (!gate_en && fault_status[FLT_OT]));
  p_latch_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_off && !host_clear) |=> latched_off);
  p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_clear |=> (fault_status == '0 && !latched_off));
endmodule

// File: tb/test_lsd_fault_supervisor.sv
module test_lsd_fault_supervisor;
  localparam int unsigned DEB = 4, COOL = 5, GOOD = 6, RETRY = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic drive_cmd = 0, oc_flag = 0, ot_flag = 0, ol_flag = 0, sg_flag = 0, host_clear = 0;
  logic gate_en, latched_off;
  logic [3:0] fault_status;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lsd_fault_supervisor #(.OC_DEB(DEB), .COOL_CNT(COOL), .GOOD_RUN(GOOD), .MAX_RETRY(RETRY))
    i_lsd_fault_supervisor (
      .clk(clk), .rst_n(rst_n), .drive_cmd(drive_cmd), .oc_flag(oc_flag),
      .ot_flag(ot_flag), .ol_flag(ol_flag), .sg_flag(sg_flag), .host_clear(host_clear),
      .gate_en(gate_en), .fault_status(fault_status), .latched_off(latched_off));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    host_clear = 1; cyc(1); host_clear = 0;
  endtask

  // thermal trip followed by a clean cool-down; gate is on on entry
  task automatic trip_and_cool(input string req);
    ot_flag = 1; cyc(1);
    check({req, " blocked after trip"}, gate_en, 0);
    ot_flag = 0; cyc(COOL - 1);
    check({req, " still cooling"}, gate_en, 0);
    cyc(1);
    check({req, " restarted"}, gate_en, 1);
  endtask

  task automatic t_reset();
    drive_cmd = 1; #1;
    check("R1 reset gate", gate_en, 0);
    check("R1 reset status", fault_status, 0);
    check("R1 reset latch", latched_off, 0);
    cyc(1); rst_n = 1; drive_cmd = 0; cyc(1);
  endtask

  task automatic t_follow();
    drive_cmd = 1; #1; check("R1 gate on", gate_en, 1);
    cyc(1); drive_cmd = 0; #1; check("R1 gate off", gate_en, 0);
    cyc(1);
  endtask

  task automatic t_oc();
    drive_cmd = 1;
    oc_flag = 1; cyc(DEB - 1); oc_flag = 0; cyc(1);
    oc_flag = 1; cyc(DEB - 1);
    check("R2 broken run no trip", latched_off, 0);
    check("R2 broken run gate", gate_en, 1);
    oc_flag = 0; cyc(1);
    oc_flag = 1; cyc(DEB - 1);
    check("R2 one short of limit", gate_en, 1);
    cyc(1);
    check("R2 gate off", gate_en, 0);
    check("R2 latched", latched_off, 1);
    check("R2 status bit0", fault_status, 4'b0001);
    oc_flag = 0;
    drive_cmd = 0; cyc(2); drive_cmd = 1; #1;
    check("R9 latch overrides cmd", gate_en, 0);
    cyc(3);
    check("R9 still off", gate_en, 0);
    do_clear(); #1;
    check("R10 status cleared", fault_status, 0);
    check("R10 latch cleared", latched_off, 0);
    check("R10 gate back", gate_en, 1);
    drive_cmd = 0; cyc(1);
  endtask

  task automatic t_oc_when_off();
    drive_cmd = 0; oc_flag = 1; cyc(DEB + 4);
    oc_flag = 0; drive_cmd = 1; cyc(1);
    check("R3 no latch", latched_off, 0);
    check("R3 no status", fault_status, 0);
    check("R3 gate on", gate_en, 1);
    drive_cmd = 0; cyc(1);
  endtask

  task automatic t_thermal();
    drive_cmd = 1; #1;
    ot_flag = 1; cyc(1);
    check("R4 gate off", gate_en, 0);
    check("R4 status bit1", fault_status, 4'b0010);
    cyc(3);
    ot_flag = 0; cyc(COOL - 2);
    ot_flag = 1; cyc(1);
    ot_flag = 0; cyc(COOL - 1);
    check("R5 count restarted", gate_en, 0);
    cyc(1);
    check("R5 restart", gate_en, 1);
    check("R5 not latched", latched_off, 0);
    // second trip uses the last restart (budget 2)
    trip_and_cool("R6 trip2");
    ot_flag = 1; cyc(1);
    check("R6 third trip latches", latched_off, 1);
    ot_flag = 0; cyc(COOL + 3);
    check("R6 stays off", gate_en, 0);
    do_clear(); #1;
    check("R10 thermal cleared", gate_en, 1);
    drive_cmd = 0; cyc(1);
  endtask

  task automatic t_good_run();
    drive_cmd = 1; #1;
    trip_and_cool("R7 trip1");
    trip_and_cool("R7 trip2");
    cyc(GOOD);
    ot_flag = 1; cyc(1);
    check("R7 budget refilled", latched_off, 0);
    check("R7 blocked", gate_en, 0);
    ot_flag = 0; cyc(COOL);
    check("R7 restart", gate_en, 1);
    drive_cmd = 0; do_clear();
  endtask

  task automatic t_diag();
    drive_cmd = 0;
    ol_flag = 1; cyc(1); ol_flag = 0; cyc(2);
    check("R8 single sample ignored", fault_status, 0);
    drive_cmd = 1; sg_flag = 1; cyc(5); #1;
    check("R8 sg ignored while on", fault_status, 0);
    check("R8 gate unaffected", gate_en, 1);
    drive_cmd = 0; cyc(1);
    check("R8 one off sample", fault_status, 0);
    cyc(1);
    check("R8 sg set bit3", fault_status, 4'b1000);
    sg_flag = 0; ol_flag = 1; cyc(2);
    check("R8 ol set bit2", fault_status, 4'b1100);
    ol_flag = 0; do_clear();
    ol_flag = 1; cyc(1); host_clear = 1; cyc(1); host_clear = 0; ol_flag = 0; cyc(1);
    check("R10 clear beats set", fault_status, 0);
  endtask

  initial begin
    cyc(2);
    t_reset();
    t_follow();
    t_oc();
    t_oc_when_off();
    t_thermal();
    t_good_run();
    t_diag();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule